// File: doc/BRIEF.md
# Serial Nibble Register Port

This block is the slave side of a three-wire synchronous serial link, clocked by a fast system clock. The host lowers an active-low select and sends eight serial-clock cycles. The first four carry a register address and the last four carry a data nibble, most significant bit first in both fields. The level of the direction pin, taken on the last rising edge, marks the frame as a read or a write. The nibble stored at the chosen location comes back on the serial output during the next frame. The output therefore runs one frame behind the address that selected it.

Two mode bits in the mode/reset register pick one of three banks. The first bank holds the thirteen time-keeping digit counters, the format/control nibble and the status nibble. The other two banks each hold fifteen nibbles of scratch storage. Address 0xF reaches the mode/reset register in every bank. A write to a digit counter does not load its data: it sends a one-cycle increment strobe to the counter logic outside the block. A write to a control or scratch location stores the nibble. A second select, driven by a supply monitor, disables the port completely. A reset bit in the mode/reset register holds the rest of the logic cleared until the host releases it through a defined pin sequence.

Top module: `nibble_serial_port`

## Requirements
- R1: A frame is eight rising edges of `sck` while `cs0_n` is low and `cs1` is high. `sin` is taken on each rising edge, address bits 3..0 first and then data bits 3..0. `wr` taken on the eighth rising edge selects read (1) or write (0).
- R2: At the end of each frame the nibble at the selected location is loaded for output. `sout` shows bit 3 until the first rising edge of the next frame. It shows bit 2, bit 1 and bit 0 after the falling edges that follow rising edges one, two and three. While the next address is being shifted in, `sout` therefore carries the previously selected data.
- R3: In the counter bank, a write to address 0x0..0xC gives one `clk` cycle of `cnt_inc` with `cnt_addr` equal to that address, and never loads the data. No strobe is given while `busy` is high. The response to that frame is the value before the increment.
- R4: A write to a control or scratch location stores the data nibble. Address 0xD of the counter bank drives `ctl1`. Scratch writes are read back unchanged.
- R5: Mode bits are bits 1:0 of the register at 0xF. Values 00 and 01 select the counter bank. Value 10 maps addresses 0x0..0xE to scratch nibbles 0..14. Value 11 maps them to nibbles 15..29. Address 0xF reads as {reset, test, mode} in every bank.
- R6: Unused counter bits read as 0. The masks per address 0x0..0xC are F,7,F,7,F,B,7,F,3,F,1,F,F. Address 0xE reads {busy, power-on flag, 0, 0}.
- R7: The power-on flag reads 1 after `rst_n` and stays 1 until the reset bit is written. After that it stays 0.
- R8: Writing 1 to bit 3 at 0xF sets the reset bit. This drives `sys_reset` high and clears `ctl1`, the mode bits and the test bit, and every write is ignored while the bit is set. The bit clears on a falling edge of `sck` seen while `cs0_n` is high.
- R9: While `cs0_n` is high, `sout_oe` is 0 and the bit count is held at zero, so each low period of `cs0_n` starts a new frame. While `cs0_n` is low and `cs1` is high, `sout_oe` is 1.
- R10: While `cs1` is low, `sout_oe` is 0 and `sck`, `sin` and `wr` are ignored. Any partly received frame is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than sck |
| rst_n | input | 1 | Power-on reset, active low |
| sck | input | 1 | Serial clock from host |
| sin | input | 1 | Serial data from host |
| wr | input | 1 | Direction: 1 read, 0 write |
| cs0_n | input | 1 | Frame select, active low |
| cs1 | input | 1 | Port enable from supply monitor, active high |
| busy | input | 1 | Carry in progress in counter logic |
| cnt_rd | input | 4 | Value of the counter digit at cnt_addr |
| sout | output | 1 | Serial data to host |
| sout_oe | output | 1 | Output enable for sout (0 = high impedance) |
| cnt_inc | output | 1 | One-cycle increment strobe for digit cnt_addr |
| cnt_addr | output | 4 | Digit address of the last frame |
| ctl1 | output | 4 | Format/control nibble |
| sys_reset | output | 1 | Reset bit, holds counter logic cleared |

## Verification
Checks run on every cycle cover the following. The bit count drops to zero while `cs1` is low, and increment strobes never follow a busy cycle and never name an address above 0xC. The power-on flag never returns to 1. The reset bit only falls while the frame select is high. The output shift register changes only on a load or a falling `sck`. The bench scenarios show the end-to-end behaviour: the one-frame delay of read data, pre-increment responses, the bank mapping of 0xF, the read masks, writes ignored under reset, and a partial frame thrown away when `cs1` drops.

// File: rtl/nibble_serial_port.sv
module nibble_serial_port #(
  parameter int SYNC_STAGES  = 2,
  parameter int BANK_NIBBLES = 15,
  parameter int LAST_COUNTER = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       sin,
  input  logic       wr,
  input  logic       cs0_n,
  input  logic       cs1,
  input  logic       busy,
  input  logic [3:0] cnt_rd,
  output logic       sout,
  output logic       sout_oe,
  output logic       cnt_inc,
  output logic [3:0] cnt_addr,
  output logic [3:0] ctl1,
  output logic       sys_reset
);
  localparam int RAM_NIBBLES = 2 * BANK_NIBBLES;
  localparam int RAM_AW = $clog2(RAM_NIBBLES);
  localparam logic [3:0] LAST_A = 4'(LAST_COUNTER);
  localparam logic [3:0] BANK_A = 4'(BANK_NIBBLES);
  localparam logic [3:0] A_CTL1 = 4'hD;
  localparam logic [3:0] A_STAT = 4'hE;
  localparam logic [3:0] A_MODE = 4'hF;
  localparam logic [4:0] SYNC_RST = 5'b01001;

  logic [4:0] syn [SYNC_STAGES];
  logic       sck_d;
  logic       sck_s, sin_s, wr_s, cs0n_s, cs1_s;
  logic       sck_rise, sck_fall, frame_ok, commit;
  logic [3:0] bitcnt;
  logic [6:0] in_sr;
  logic [3:0] fr_a, fr_d;
  logic       load_q, sel_ram, sel_hi;
  logic [3:0] out_sr, rd_mux;
  logic [3:0] cr1;
  logic [1:0] ms;
  logic       test_b, sysr, ponc;
  logic [3:0] ram [RAM_NIBBLES];
  logic [RAM_AW-1:0] widx, ridx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) syn[i] <= SYNC_RST;
      sck_d <= 1'b1;
    end else begin
      syn[0] <= {cs1, cs0_n, wr, sin, sck};
      for (int i = 1; i < SYNC_STAGES; i++) syn[i] <= syn[i-1];
      sck_d <= sck_s;
    end
  end

  assign {cs1_s, cs0n_s, wr_s, sin_s, sck_s} = syn[SYNC_STAGES-1];
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign frame_ok = cs1_s & ~cs0n_s;
  assign commit   = frame_ok & sck_rise & (bitcnt == 4'd7);
  assign {fr_a, fr_d} = {in_sr, sin_s};
  assign widx = ms[0] ? RAM_AW'(fr_a) + RAM_AW'(BANK_NIBBLES) : RAM_AW'(fr_a);
  assign ridx = sel_hi ? RAM_AW'(cnt_addr) + RAM_AW'(BANK_NIBBLES) : RAM_AW'(cnt_addr);

  function automatic logic [3:0] digit_mask(input logic [3:0] a);
    case (a)
      4'h1, 4'h3, 4'h6: digit_mask = 4'h7;
      4'h5:             digit_mask = 4'hB;
      4'h8:             digit_mask = 4'h3;
      4'hA:             digit_mask = 4'h1;
      default:          digit_mask = 4'hF;
    endcase
  endfunction

  always_comb begin
    if (cnt_addr == A_MODE)                      rd_mux = {sysr, test_b, ms};
    else if (sel_ram && cnt_addr < BANK_A)       rd_mux = ram[ridx];
    else if (sel_ram)                            rd_mux = 4'h0;
    else if (cnt_addr == A_STAT)                 rd_mux = {busy, ponc, 2'b00};
    else if (cnt_addr == A_CTL1)                 rd_mux = cr1;
    else if (cnt_addr <= LAST_A)                 rd_mux = cnt_rd & digit_mask(cnt_addr);
    else                                         rd_mux = 4'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0;
      in_sr  <= '0;
    end else if (!frame_ok) begin
      bitcnt <= '0;
    end else if (sck_rise) begin
      in_sr  <= {in_sr[5:0], sin_s};
      bitcnt <= (bitcnt == 4'd8) ? 4'd1 : bitcnt + 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q   <= 1'b0;
      cnt_inc  <= 1'b0;
      cnt_addr <= '0;
      sel_ram  <= 1'b0;
      sel_hi   <= 1'b0;
      out_sr   <= '0;
    end else begin
      load_q  <= commit;
      cnt_inc <= commit & ~wr_s & ~ms[1] & (fr_a <= LAST_A) & ~busy & ~sysr;
      if (commit) begin
        cnt_addr <= fr_a;
        sel_ram  <= ms[1];
        sel_hi   <= ms[0];
      end
      if (load_q)
        out_sr <= rd_mux;
      else if (frame_ok && sck_fall && bitcnt != 4'd0 && bitcnt != 4'd8)
        out_sr <= {out_sr[2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr1    <= '0;
      ms     <= '0;
      test_b <= 1'b0;
      sysr   <= 1'b0;
      ponc   <= 1'b1;
      for (int i = 0; i < RAM_NIBBLES; i++) ram[i] <= '0;
    end else if (commit && !wr_s && !sysr) begin
      if (fr_a == A_MODE) begin
        if (fr_d[3]) begin
          sysr   <= 1'b1;
          ponc   <= 1'b0;
          cr1    <= '0;
          ms     <= '0;
          test_b <= 1'b0;
        end else begin
          ms     <= fr_d[1:0];
          test_b <= fr_d[2];
        end
      end else if (ms[1]) begin
        if (fr_a < BANK_A) ram[widx] <= fr_d;
      end else if (fr_a == A_CTL1) begin
        cr1 <= fr_d;
      end
    end else if (sysr && cs1_s && cs0n_s && sck_fall) begin
      sysr <= 1'b0;
    end
  end

  assign sout      = out_sr[3];
  assign sout_oe   = frame_ok;
  assign ctl1      = cr1;
  assign sys_reset = sysr;

  // R10
  cs1_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs1_s |=> (bitcnt == 4'd0));
  // R3
  inc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_inc |-> !$past(busy));
  // R3
  inc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_inc |-> (cnt_addr <= LAST_A));
  // R7
  ponc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ponc) |-> !ponc);
  // R8
  sysr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sysr) |-> $past(cs0n_s));
  // R2
  sout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_q) && !$past(sck_fall)) |-> $stable(out_sr));
endmodule

// File: tb/tb_nibble_serial_port.sv
module tb_nibble_serial_port;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b1, sin = 1'b0, wr = 1'b1, cs0_n = 1'b1, cs1 = 1'b1, busy = 1'b0;
  logic [3:0] cnt_rd;
  logic sout, sout_oe, cnt_inc, sys_reset;
  logic [3:0] cnt_addr, ctl1;

  int total = 0, bad = 0;
  bit done = 0;

  logic [3:0] cnt_val [13];
  logic [3:0] m_cnt [13];
  logic [3:0] m_ram [30];
  logic [3:0] m_cr1 = 4'h0;
  logic [1:0] m_ms = 2'b00;
  logic m_test = 1'b0, m_sysr = 1'b0, m_ponc = 1'b1;
  logic [3:0] pend = 4'h0;

  always #2.5 clk = ~clk;

  nibble_serial_port dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .sin(sin), .wr(wr), .cs0_n(cs0_n),
    .cs1(cs1), .busy(busy), .cnt_rd(cnt_rd), .sout(sout), .sout_oe(sout_oe),
    .cnt_inc(cnt_inc), .cnt_addr(cnt_addr), .ctl1(ctl1), .sys_reset(sys_reset)
  );

  assign cnt_rd = (cnt_addr <= 4'd12) ? cnt_val[cnt_addr] : 4'h0;

  always @(posedge clk)
    if (cnt_inc && cnt_addr <= 4'd12) cnt_val[cnt_addr] <= cnt_val[cnt_addr] + 4'd1;

  function automatic logic [3:0] mask_of(input logic [3:0] a);
    logic [3:0] tbl [13] = '{4'hF, 4'h7, 4'hF, 4'h7, 4'hF, 4'hB, 4'h7, 4'hF, 4'h3, 4'hF, 4'h1, 4'hF, 4'hF};
    return (a <= 4'd12) ? tbl[a] : 4'h0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input logic [3:0] a, d, input logic rd, output logic [3:0] r);
    bit ram_b = m_ms[1];
    int idx = m_ms[0] ? int'(a) + 15 : int'(a);
    logic [3:0] pre = (a <= 4'd12) ? (m_cnt[a] & mask_of(a)) : 4'h0;
    if (!rd && !m_sysr) begin
      if (a == 4'hF) begin
        if (d[3]) begin
          m_sysr = 1; m_ms = 0; m_test = 0; m_cr1 = 0; m_ponc = 0;
        end else begin
          m_ms = d[1:0]; m_test = d[2];
        end
      end else if (ram_b) m_ram[idx] = d;
      else if (a == 4'hD) m_cr1 = d;
      else if (a <= 4'd12 && !busy) m_cnt[a] = m_cnt[a] + 4'd1;
    end
    if (a == 4'hF) r = {m_sysr, m_test, m_ms};
    else if (ram_b) r = m_ram[idx];
    else if (a == 4'hE) r = {busy, m_ponc, 2'b00};
    else if (a == 4'hD) r = m_cr1;
    else r = pre;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [3:0] a, d, input logic rd, input bit chk, input string req);
    logic [3:0] got = 4'h0;
    logic [7:0] fr = {a, d};
    logic [3:0] nx;
    cs0_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < 8; i++) begin
      sck = 1'b0; sin = fr[7-i]; wr = rd;
      wait_clk(HALF);
      if (i < 4) got[3-i] = sout;
      if (i == 0) check(sout_oe == 1'b1, "R9 oe in frame", sout_oe, 1);
      sck = 1'b1;
      wait_clk(HALF);
    end
    wait_clk(HALF);
    cs0_n = 1'b1;
    wait_clk(HALF);
    // R2 response of previous frame, R1 framing
    if (chk) check(got == pend, req, got, pend);
    model(a, d, rd, nx);
    pend = nx;
    check(ctl1 == m_cr1, "R4 ctl1", ctl1, m_cr1);
    check(sys_reset == m_sysr, "R8 sys_reset", sys_reset, m_sysr);
    check(sout_oe == 1'b0, "R9 oe idle", sout_oe, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 13; i++) begin
      cnt_val[i] = 4'(i * 3 + 1);
      m_cnt[i]   = 4'(i * 3 + 1);
    end
    for (int i = 0; i < 30; i++) m_ram[i] = 4'h0;
    wait_clk(10);
    rst_n = 1'b1;
    wait_clk(10);
    check(sout_oe == 1'b0, "R9 reset oe", sout_oe, 0);
    check(sys_reset == 1'b0, "R8 reset", sys_reset, 0);
    check(ctl1 == 4'h0, "R4 reset ctl1", ctl1, 0);

    xfer(4'hE, 4'h0, 1, 1, "R2 reset data");
    xfer(4'h5, 4'h0, 1, 1, "R7 ponc after power-up");
    xfer(4'h8, 4'h0, 1, 1, "R6 mask 0x5");
    xfer(4'hA, 4'h0, 0, 1, "R6 mask 0x8");
    xfer(4'hA, 4'h0, 1, 1, "R3 pre-increment");
    xfer(4'hD, 4'h6, 0, 1, "R3 post-increment read");
    busy = 1'b1;
    xfer(4'h2, 4'h9, 0, 1, "R4 ctl1 readback");
    xfer(4'h2, 4'h0, 1, 1, "R3 busy write");
    xfer(4'hE, 4'h0, 1, 1, "R3 busy suppresses inc");
    busy = 1'b0;
    xfer(4'hF, 4'h2, 0, 1, "R6 status with busy");
    xfer(4'hE, 4'hC, 0, 1, "R5 mode 10 readback");
    xfer(4'hF, 4'h3, 0, 1, "R5 ram low nibble 14");
    xfer(4'hE, 4'h7, 0, 1, "R5 mode 11 at 0xF");
    xfer(4'hF, 4'h2, 0, 1, "R5 ram high nibble 29");
    xfer(4'hE, 4'h0, 1, 1, "R5 back to mode 10");
    xfer(4'h5, 4'hA, 0, 1, "R5 low bank kept");

    // R10 partial frame then ignored frame while cs1 low
    cs0_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < 3; i++) begin
      sck = 1'b0; sin = 1'b1; wait_clk(HALF); sck = 1'b1; wait_clk(HALF);
    end
    cs1 = 1'b0;
    wait_clk(HALF);
    check(sout_oe == 1'b0, "R10 oe with cs1 low", sout_oe, 0);
    for (int i = 0; i < 8; i++) begin
      sck = 1'b0; sin = (8'h53 >> (7 - i)) & 8'h1; wr = 1'b0;
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF);
    end
    cs1 = 1'b1;
    wait_clk(HALF);
    xfer(4'h5, 4'h0, 1, 0, "R10");
    xfer(4'h0, 4'h0, 1, 1, "R10 ignored write and discarded bits");

    // R8 system reset
    xfer(4'hF, 4'h8, 0, 1, "R8 prep");
    xfer(4'hD, 4'h5, 0, 1, "R8 reset bit readback");
    xfer(4'hD, 4'h0, 1, 1, "R8 ignored write");
    xfer(4'hE, 4'h0, 1, 1, "R8 ctl1 cleared");
    check(sys_reset == 1'b1, "R8 held", sys_reset, 1);
    sck = 1'b0; wait_clk(HALF); sck = 1'b1; wait_clk(HALF);
    check(sys_reset == 1'b0, "R8 release", sys_reset, 0);
    m_sysr = 1'b0;
    xfer(4'hF, 4'h0, 1, 1, "R7 ponc cleared");
    xfer(4'hD, 4'h0, 1, 1, "R8 mode reg after release");

    for (int n = 0; n < 240; n++) begin
      logic [3:0] a = 4'($urandom % 16);
      logic [3:0] d = 4'($urandom % 16);
      logic rd = 1'($urandom % 2);
      if (a == 4'hF) d[3] = 1'b0;
      if (($urandom % 8) == 0) busy = ~busy;
      xfer(a, d, rd, 1, (a == 4'hF) ? "R5 random" : (m_ms[1] ? "R4 random" : "R3 random"));
    end
    busy = 1'b0;
    xfer(4'h0, 4'h0, 1, 1, "R1 final");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule